// File: doc/BRIEF.md
# Masked Interrupt Aggregator

This block collects up to 32 interrupt sources from peripherals and external pins into one set of sticky pending flags and drives a single interrupt line towards the processor. Software reaches it through a word-wide register port. Three registers share the same pending flags. The status register shows every pending flag whether or not it is enabled. The cause register shows only the pending flags that are enabled. The mask register holds one enable per source.

Software clears a pending flag by writing a one to its bit in the status register. It raises a flag without hardware involvement by writing a one to its bit in the cause register. The interrupt line is high whenever at least one enabled flag is pending. It is registered, so it trails the pending state by one clock.

The implemented positions are fixed by the bit layout of the subsystem. Bits 31 and 30 are two memory error classes. Bits 23 and 22 are access violations. Bits 21 to 17 and bits 15 to 11 are two groups of five serial-port events. Bits 9 to 0 are external pins. All other positions are reserved.

Top module: `irq_aggregator`

## Requirements
- R1: After synchronous reset, status, cause and mask all read zero, `cpu_irq` is low and `reg_rdata` is zero.
- R2: A source input that is high at a rising clock edge sets its pending bit at that edge, and the bit stays set after the source returns low.
- R3: A read of the status register (offset 0x184) returns every pending bit regardless of the mask.
- R4: A write to status clears each pending bit whose written data bit is 1 and leaves bits written with 0 unchanged.
- R5: When a source sets a bit in the same cycle as a status write clears it, the bit ends up set.
- R6: A read of the cause register (offset 0x188) returns the pending bits ANDed bitwise with the mask.
- R7: A write to cause sets each pending bit whose written data bit is 1 and leaves the other bits unchanged.
- R8: A write to the mask register (offset 0x18C) replaces the enables with the written data, and a later read of the mask returns that data.
- R9: `cpu_irq` after a clock edge equals the OR of (pending AND mask) as it stood before that edge, which is one cycle of latency.
- R10: The implemented-bit mask is 0xC0FEFBFF. Reserved positions (bits 29..24, 16 and 10) always read as zero and ignore writes to status, cause and mask as well as source inputs.
- R11: A read at any other offset returns zero, and a write there changes no register.
- R12: A read strobe in one cycle presents the register value on `reg_rdata` after the next rising edge. That value is the one the register held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| src_irq | input | 32 | Interrupt source inputs, one per bit position |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
The first pattern is a single source pulse with the mask cleared. It separates the raw status view from the masked cause view, and it shows that the line stays low. Overlapping multi-bit source patterns under a partial mask confirm that cause is a true bitwise AND and not an OR or a copy of status. A source and a status clear aimed at the same bit in one cycle decide the set-versus-clear priority. Writes of all ones to status, cause, mask and an unmapped offset, together with sources on reserved positions, tell implemented bits apart from reserved ones and mapped offsets apart from unmapped ones.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int AGG_DW = 32;
  localparam int AGG_AW = 12;
  localparam logic [AGG_AW-1:0] OFS_STATUS = 12'h184;
  localparam logic [AGG_AW-1:0] OFS_CAUSE  = 12'h188;
  localparam logic [AGG_AW-1:0] OFS_MASK   = 12'h18C;
  // live positions: 31,30, 23..17, 15..11, 9..0
  localparam logic [AGG_DW-1:0] LIVE_BITS  = 32'hC0FE_FBFF;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_CAUSE  = 2'd2,
    SEL_MASK   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_agg_pkg::*;
#(
  parameter int AW = AGG_AW,
  parameter logic [AW-1:0] STATUS_AT = OFS_STATUS,
  parameter logic [AW-1:0] CAUSE_AT  = OFS_CAUSE,
  parameter logic [AW-1:0] MASK_AT   = OFS_MASK
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel
);
  always_comb begin
    if (addr == STATUS_AT)     sel = SEL_STATUS;
    else if (addr == CAUSE_AT) sel = SEL_CAUSE;
    else if (addr == MASK_AT)  sel = SEL_MASK;
    else                       sel = SEL_NONE;
  end
endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int DW = 32,
  parameter logic [DW-1:0] LIVE = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] clr_i,
  input  logic [DW-1:0] set_i,
  output logic [DW-1:0] pend_o
);
  logic [DW-1:0] pend_q;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (LIVE[b]) begin : g_live
      always_ff @(posedge clk) begin
        if (rst)                     pend_q[b] <= 1'b0;
        else if (src_i[b] | set_i[b]) pend_q[b] <= 1'b1;
        else if (clr_i[b])           pend_q[b] <= 1'b0;
      end
    end else begin : g_rsvd
      assign pend_q[b] = 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R2 R5
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|(src_i & LIVE)) |=> ((pend_o & $past(src_i & LIVE)) == $past(src_i & LIVE)));
  // R4
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~src_i & ~set_i & LIVE)) |=>
      ((pend_o & $past(clr_i & ~src_i & ~set_i & LIVE)) == '0));
  // R7
  force_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|(set_i & LIVE)) |=> ((pend_o & $past(set_i & LIVE)) == $past(set_i & LIVE)));
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] pend_i,
  input  logic [DW-1:0] mask_i,
  output logic [DW-1:0] cause_o,
  output logic          irq_o
);
  assign cause_o = pend_i & mask_i;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |cause_o;
  end

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past((pend_i & mask_i) != '0));
  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_o) |-> $past((pend_i & mask_i) == '0));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int DW = AGG_DW,
  parameter int AW = AGG_AW,
  parameter logic [DW-1:0] LIVE = LIVE_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] src_irq,
  output logic          cpu_irq
);
  reg_sel_e      sel;
  logic [DW-1:0] pend, cause, mask_q;
  logic [DW-1:0] clr_v, set_v;

  irq_addr_decode #(.AW(AW)) u_dec (.addr(reg_addr), .sel(sel));

  assign clr_v = (reg_wr && sel == SEL_STATUS) ? reg_wdata : '0;
  assign set_v = (reg_wr && sel == SEL_CAUSE)  ? reg_wdata : '0;

  irq_pending_bank #(.DW(DW), .LIVE(LIVE)) u_bank (
    .clk(clk), .rst(rst), .src_i(src_irq), .clr_i(clr_v), .set_i(set_v),
    .pend_o(pend)
  );

  always_ff @(posedge clk) begin
    if (rst)                            mask_q <= '0;
    else if (reg_wr && sel == SEL_MASK) mask_q <= reg_wdata & LIVE;
  end

  irq_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .pend_i(pend), .mask_i(mask_q),
    .cause_o(cause), .irq_o(cpu_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      unique case (sel)
        SEL_STATUS: reg_rdata <= pend;
        SEL_CAUSE:  reg_rdata <= cause;
        SEL_MASK:   reg_rdata <= mask_q;
        default:    reg_rdata <= '0;
      endcase
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!cpu_irq && reg_rdata == '0));
  // R8
  mask_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && sel == SEL_MASK) |=> (mask_q == $past(reg_wdata & LIVE)));
  // R10
  rsvd_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~LIVE) == '0);
  // R11
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && sel == SEL_NONE) |=> (reg_rdata == '0));
endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  localparam logic [31:0] LIVE = 32'hC0FE_FBFF;
  localparam logic [11:0] A_ST = 12'h184, A_CS = 12'h188, A_MK = 12'h18C, A_NO = 12'h190;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, src_irq = '0, reg_rdata;
  logic cpu_irq;

  always #10 clk = ~clk;

  irq_aggregator u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_irq(src_irq), .cpu_irq(cpu_irq)
  );

  int n_chk = 0, n_fail = 0;
  bit ended = 0;
  logic [31:0] m_pend = '0, m_mask = '0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_d = 1'b0;

  always @(posedge clk) rd_d <= reg_rd;

  // monitor: pop expected read data one cycle after each read strobe (R12)
  always @(negedge clk) begin
    if (rd_d && !rst && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (reg_rdata !== e) begin
        n_fail++;
        $display("FAIL %s R12: reg_rdata actual %h expected %h", t, reg_rdata, e);
      end
    end
  end

  task automatic step(input bit wr, input bit rd, input logic [11:0] a,
                      input logic [31:0] d, input logic [31:0] s, input string tag);
    logic [31:0] nxt;
    logic irq_e;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; src_irq = s;
    if (rd) begin
      exp_q.push_back((a == A_ST) ? m_pend : (a == A_CS) ? (m_pend & m_mask) :
                      (a == A_MK) ? m_mask : 32'h0);
      tag_q.push_back(tag);
    end
    irq_e = |(m_pend & m_mask);
    nxt = m_pend;
    if (wr && a == A_ST) nxt = nxt & ~d;
    nxt = nxt | s;
    if (wr && a == A_CS) nxt = nxt | d;
    m_pend = nxt & LIVE;
    if (wr && a == A_MK) m_mask = d & LIVE;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; src_irq = '0;
    n_chk++;
    if (cpu_irq !== irq_e) begin
      n_fail++;
      $display("FAIL %s R9: cpu_irq actual %0b expected %0b", tag, cpu_irq, irq_e);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n_chk++;
    if (cpu_irq !== 1'b0 || reg_rdata !== 32'h0) begin
      n_fail++;
      $display("FAIL R1: irq/rdata actual %0b/%h expected 0/0", cpu_irq, reg_rdata);
    end
    step(0, 1, A_ST, 0, 0, "R1");
    step(0, 1, A_CS, 0, 0, "R1");
    step(0, 1, A_MK, 0, 0, "R1");
    // single pulse, mask cleared
    step(0, 0, 0, 0, 32'h1, "R2");
    step(0, 0, 0, 0, 0, "R2");
    step(0, 1, A_ST, 0, 0, "R2");
    step(0, 1, A_ST, 0, 0, "R3");
    step(0, 1, A_CS, 0, 0, "R6");
    // enable it
    step(1, 0, A_MK, 32'h1, 0, "R8");
    step(0, 1, A_MK, 0, 0, "R8");
    step(0, 0, 0, 0, 0, "R9");
    // write-one-to-clear
    step(1, 0, A_ST, 32'h0, 0, "R4");
    step(0, 1, A_ST, 0, 0, "R4");
    step(1, 0, A_ST, 32'h1, 0, "R4");
    step(0, 1, A_ST, 0, 0, "R4");
    step(0, 0, 0, 0, 0, "R9");
    // set beats clear
    step(1, 0, A_ST, 32'h8, 32'h8, "R5");
    step(0, 1, A_ST, 0, 0, "R5");
    // forced set, including a reserved position
    step(1, 0, A_CS, 32'h8000_0400, 0, "R7");
    step(0, 1, A_ST, 0, 0, "R7");
    step(0, 1, A_CS, 0, 0, "R6");
    // reserved sources
    step(0, 0, 0, 0, 32'h3F01_0400, "R10");
    step(0, 1, A_ST, 0, 0, "R10");
    step(1, 0, A_MK, 32'hFFFF_FFFF, 0, "R10");
    step(0, 1, A_MK, 0, 0, "R10");
    step(0, 1, A_CS, 0, 0, "R6");
    // unmapped offset
    step(1, 0, A_NO, 32'hFFFF_FFFF, 0, "R11");
    step(0, 1, A_NO, 0, 0, "R11");
    step(0, 1, A_ST, 0, 0, "R11");
    step(0, 1, A_MK, 0, 0, "R11");
    // clear everything, line must drop
    step(1, 0, A_ST, 32'hFFFF_FFFF, 0, "R4");
    step(0, 1, A_ST, 0, 0, "R4");
    step(0, 0, 0, 0, 0, "R9");
    // overlapping multi-bit pattern under partial mask
    step(1, 0, A_MK, 32'h0002_0001, 0, "R8");
    step(0, 0, 0, 0, 32'h00A2_0200, "R6");
    step(0, 1, A_CS, 0, 0, "R6");
    step(0, 1, A_ST, 0, 0, "R3");
    step(0, 0, 0, 0, 32'h4000_0001, "R6");
    step(0, 1, A_CS, 0, 0, "R6");
    step(1, 0, A_ST, 32'h0002_0001, 0, "R4");
    step(0, 1, A_CS, 0, 0, "R6");
    step(0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, "R9");
    finish_run();
  end
endmodule